// File: doc/BRIEF.md
# Glitch-Free Divided Clock Mode Controller

This block turns one fast reference clock into three families of derived clocks: a set of core clocks, a single lead clock that runs one reference period ahead of the core clocks, and a set of system-bus clocks. All of them come from one free-running phase counter, with no PLL involved. The reference is taken to run at twice the base frequency F. Three active-low control inputs choose among three actions: divide the clocks down (a slow request and a bus-width choice), park the clocks low, or float every output. Every change of divide ratio and every stop or restart is timed so that only whole high and whole low phases appear on the pins.

The control inputs go through a two-flop synchronizer. A new mode or ratio takes effect only at the end of the slowest divider period, an eight-reference-cycle frame, because at that point every derived waveform has just completed a high phase. The core clocks are a one-cycle delayed copy of the lead clock. They park at the end of their current high phase and restart only at the start of a frame. The sleep mode is never entered or left directly. The controller always passes through the core-parked mode for at least one frame. Three externally produced fixed clocks (fast, slow and a reference copy) are passed through with gating: sleep silences the fast and slow ones, and the float mode disables all of them.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With park_req_n=1 and slow_req_n=1, lead_clk_o and every core_clk_o bit toggle every reference cycle (frequency F). Every sys_clk_o bit toggles every cycle when bus_wide_n=1 and every two cycles when bus_wide_n=0.
- R2: With park_req_n=1 and slow_req_n=0, lead and core clocks toggle every two cycles (F/2). The bus clocks toggle every two cycles when bus_wide_n=1 and every four cycles when bus_wide_n=0.
- R3: All core_clk_o bits are identical and all sys_clk_o bits are identical. While the core clocks run, core_clk_o equals lead_clk_o delayed by exactly one reference cycle.
- R4: Control code {park_req_n,bus_wide_n,slow_req_n}=3'b001 holds the core clocks low, while the lead clock runs at F and the bus clocks run at F/2.
- R5: Code 3'b011 holds core, lead and bus clocks low.
- R6: Code 3'b010 drives every output-enable low and holds every derived clock low. In every other code, all output-enables are high.
- R7: Code 3'b000 (sleep) holds all derived clocks low and forces fix_o[1:0] low, while fix_o[2] keeps following fix_i[2]. Outside codes 3'b000 and 3'b010, fix_o equals fix_i.
- R8: Sleep is entered only from the core-parked mode and left only into it. A request that would enter or leave sleep from any other mode runs the lead clock with the core clocks parked for at least one frame first.
- R9: No high pulse on any derived clock is shorter than the smaller of the half-periods in force before and after a change. A parked core clock always completes its current high phase.
- R10: No low pulse is shorter than that same bound. After a stop, every restarted clock begins with at least one full low phase.
- R11: A control change has no effect on the outputs for the first three reference edges after it is applied, because of the synchronizer and the frame boundary. Divide ratios change only at the wrap of the eight-cycle phase counter.
- R12: While rst_n is low, all derived clocks are low, all output-enables are high and fix_o follows fix_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at 2F |
| rst_n | input | 1 | Synchronous active-low reset |
| park_req_n | input | 1 | Active-low stop request |
| bus_wide_n | input | 1 | Bus ratio choice: 1 gives bus at core rate, 0 gives half rate |
| slow_req_n | input | 1 | Active-low request to halve all derived rates |
| fix_i | input | 3 | Fixed clocks: [0] fast, [1] slow, [2] reference copy |
| core_clk_o | output | NCORE | Core clocks |
| core_oe_o | output | NCORE | Output-enables for core clocks |
| lead_clk_o | output | 1 | Early clock, one reference period ahead of the core clocks |
| lead_oe_o | output | 1 | Output-enable for the lead clock |
| sys_clk_o | output | NSYS | Bus clocks |
| sys_oe_o | output | NSYS | Output-enables for bus clocks |
| fix_o | output | 3 | Gated fixed clocks |
| fix_oe_o | output | 3 | Output-enables for fixed clocks |

## Verification
The bench drives every ordered pair of the eight control codes. It checks the steady waveform of each code for period, phase, the one-cycle core lag and the pin gating. A pulse-width monitor watches every transition, so a design that switched ratio mid-frame, or parked a core clock in the middle of a high phase, would show a runt that is shorter than the bound. Transitions into and out of sleep must show a stretch where the lead clock toggles while the core clocks stay low. A design that jumped straight to sleep would produce no such stretch. A check right after a ratio change confirms that the old rate persists for three edges, so a missing synchronizer stage would appear as an early change.

// File: rtl/clk_mode_pkg.sv
// Shared types and decode helpers for the divided clock mode controller.
// Assumes the slowest derived clock has a half-period of 2**SLOW_SH reference cycles.
package clk_mode_pkg;

    localparam int SLOW_SH = 2;
    localparam int PH_W    = SLOW_SH + 1;

    typedef enum logic [2:0] {
        MD_RUN,
        MD_PARK_CORE,
        MD_HALT_ALL,
        MD_FLOAT,
        MD_SLEEP
    } mode_e;

    // Half-period exponents: toggling every 2**sh reference cycles
    typedef struct packed {
        logic [1:0] core_sh;
        logic [1:0] bus_sh;
    } ratio_t;

    // Map the active-low control code to a requested mode
    function automatic mode_e decode_mode(input logic park_n, input logic wide_n,
                                          input logic slow_n);
        if (park_n) return MD_RUN;
        case ({wide_n, slow_n})
            2'b01:   return MD_PARK_CORE;
            2'b11:   return MD_HALT_ALL;
            2'b10:   return MD_FLOAT;
            default: return MD_SLEEP;
        endcase
    endfunction

    // Divide exponents chosen by the slow request and the bus width choice
    function automatic ratio_t ratio_of(input logic wide_n, input logic slow_n);
        ratio_t r;
        r.core_sh = slow_n ? 2'd0 : 2'd1;
        r.bus_sh  = r.core_sh + {1'b0, ~wide_n};
        return r;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
// Multi-stage synchronizer for the asynchronous control inputs.
// Assumes inputs are quasi-static; resets to all ones (every request deasserted).
module ctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/phase_ctr.sv
// Free-running phase counter shared by every divider; its top bit spans the slowest period.
// Assumes all divide ratios are powers of two no larger than 2**(W-1).
module phase_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    // Count reference cycles
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = &cnt_o;
endmodule

// File: rtl/mode_seq.sv
// Applies requested modes and ratios at frame boundaries only, and routes every
// entry to or exit from sleep through the core-parked mode for one frame.
// Assumes ctl_i is already synchronized and ordered {park_n, wide_n, slow_n}.
module mode_seq
    import clk_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ctl_i,
    input  logic       wrap_i,
    output mode_e      mode_o,
    output ratio_t     ratio_o
);
    mode_e  tgt;
    mode_e  nxt;
    ratio_t nxt_ratio;

    // Choose the next mode, inserting the parked step around sleep
    always_comb begin
        tgt = decode_mode(ctl_i[2], ctl_i[1], ctl_i[0]);
        if (tgt == MD_SLEEP && mode_o != MD_SLEEP && mode_o != MD_PARK_CORE)
            nxt = MD_PARK_CORE;
        else if (mode_o == MD_SLEEP && tgt != MD_SLEEP && tgt != MD_PARK_CORE)
            nxt = MD_PARK_CORE;
        else
            nxt = tgt;
        nxt_ratio = (nxt != tgt) ? ratio_of(1'b0, 1'b1) : ratio_of(ctl_i[1], ctl_i[0]);
    end

    // Commit mode and ratio at the frame wrap, when every waveform is ending high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= MD_RUN;
            ratio_o <= ratio_of(1'b1, 1'b1);
        end else if (wrap_i) begin
            mode_o  <= nxt;
            ratio_o <= nxt_ratio;
        end
    end

    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_SLEEP && $past(mode_o) != MD_SLEEP) |-> $past(mode_o) == MD_PARK_CORE);
    // R8
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == MD_SLEEP && mode_o != MD_SLEEP) |-> mode_o == MD_PARK_CORE);
endmodule

// File: rtl/clk_gen.sv
// Derives lead, core and bus clocks from the phase counter and gates them per mode.
// Core clocks are the lead waveform delayed one cycle; they park only when that
// waveform is low and restart only at frame start. Assumes the ratio changes only at wrap.
module clk_gen
    import clk_mode_pkg::*;
#(
    parameter int NCORE = 3,
    parameter int NSYS  = 6,
    parameter int CW    = PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt_i,
    input  mode_e            mode_i,
    input  ratio_t           ratio_i,
    output logic [NCORE-1:0] core_clk_o,
    output logic             lead_clk_o,
    output logic [NSYS-1:0]  sys_clk_o
);
    logic wave_lead, wave_bus;
    logic lead_run, core_want;
    logic core_wave_q, core_run_q;

    // Select the divider taps and the per-family run conditions
    always_comb begin
        wave_lead = cnt_i[ratio_i.core_sh];
        wave_bus  = cnt_i[ratio_i.bus_sh];
        lead_run  = (mode_i == MD_RUN) || (mode_i == MD_PARK_CORE);
        core_want = (mode_i == MD_RUN);
    end

    // Register the lead clock and every bus clock bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_clk_o <= 1'b0;
            sys_clk_o  <= '0;
        end else begin
            lead_clk_o <= wave_lead & lead_run;
            for (int i = 0; i < NSYS; i++) sys_clk_o[i] <= wave_bus & lead_run;
        end
    end

    // Core run gate: drop while the waveform is low, raise only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_wave_q <= 1'b0;
            core_run_q  <= 1'b0;
        end else begin
            core_wave_q <= wave_lead;
            if (core_want) begin
                if (cnt_i == '0) core_run_q <= 1'b1;
            end else if (!wave_lead) begin
                core_run_q <= 1'b0;
            end
        end
    end

    // Register every core clock bit as the delayed, gated lead waveform
    always_ff @(posedge clk) begin
        if (!rst_n) core_clk_o <= '0;
        else for (int i = 0; i < NCORE; i++) core_clk_o[i] <= core_wave_q & core_run_q;
    end

    // R11
    ratio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i != $past(ratio_i)) |-> (cnt_i == '0));
    // R3
    core_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_o[0]) |-> $past(lead_clk_o));
endmodule

// File: rtl/clk_mode_ctrl.sv
// Top: synchronizes the control code, runs the phase counter and mode sequencer,
// generates the derived clocks and gates the fixed pass-through clocks and enables.
// Assumes clk runs at twice the base frequency and fix_i comes from outside.
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int NCORE = 3,
    parameter int NSYS  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_req_n,
    input  logic             bus_wide_n,
    input  logic             slow_req_n,
    input  logic [2:0]       fix_i,
    output logic [NCORE-1:0] core_clk_o,
    output logic [NCORE-1:0] core_oe_o,
    output logic             lead_clk_o,
    output logic             lead_oe_o,
    output logic [NSYS-1:0]  sys_clk_o,
    output logic [NSYS-1:0]  sys_oe_o,
    output logic [2:0]       fix_o,
    output logic [2:0]       fix_oe_o
);
    logic [2:0]      ctl_s;
    logic [PH_W-1:0] cnt;
    logic            wrap;
    mode_e           mode;
    ratio_t          ratio;
    logic            drive_on, fixed_on;

    ctl_sync #(.W(3), .STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({park_req_n, bus_wide_n, slow_req_n}), .q_o(ctl_s)
    );

    phase_ctr #(.W(PH_W)) i_phase (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap)
    );

    mode_seq i_seq (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .wrap_i(wrap),
        .mode_o(mode), .ratio_o(ratio)
    );

    clk_gen #(.NCORE(NCORE), .NSYS(NSYS), .CW(PH_W)) i_gen (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .mode_i(mode), .ratio_i(ratio),
        .core_clk_o(core_clk_o), .lead_clk_o(lead_clk_o), .sys_clk_o(sys_clk_o)
    );

    // Output-enables and fixed clock gating from the committed mode
    always_comb begin
        drive_on  = (mode != MD_FLOAT);
        fixed_on  = drive_on && (mode != MD_SLEEP);
        core_oe_o = {NCORE{drive_on}};
        lead_oe_o = drive_on;
        sys_oe_o  = {NSYS{drive_on}};
        fix_oe_o  = {3{drive_on}};
        fix_o     = {fix_i[2] & drive_on, fix_i[1] & fixed_on, fix_i[0] & fixed_on};
    end

    // R6
    float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead_oe_o && $past(!lead_oe_o)) |-> (lead_clk_o == 1'b0 && sys_clk_o == '0));
endmodule

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;
    localparam int NCORE = 3;
    localparam int NSYS  = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, park_req_n, bus_wide_n, slow_req_n;
    logic [2:0] fix_i;
    logic [NCORE-1:0] core_clk_o, core_oe_o;
    logic lead_clk_o, lead_oe_o;
    logic [NSYS-1:0] sys_clk_o, sys_oe_o;
    logic [2:0] fix_o, fix_oe_o;

    clk_mode_ctrl #(.NCORE(NCORE), .NSYS(NSYS)) i_clk_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .park_req_n(park_req_n), .bus_wide_n(bus_wide_n),
        .slow_req_n(slow_req_n), .fix_i(fix_i), .core_clk_o(core_clk_o),
        .core_oe_o(core_oe_o), .lead_clk_o(lead_clk_o), .lead_oe_o(lead_oe_o),
        .sys_clk_o(sys_clk_o), .sys_oe_o(sys_oe_o), .fix_o(fix_o), .fix_oe_o(fix_oe_o)
    );

    int checks = 0, fails = 0;
    int floor_c = 1, floor_e = 1, floor_b = 1;
    logic [2:0] cur = 3'b111;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected half-periods per code {park_n, wide_n, slow_n}; 0 means held low
    function automatic int h_lead(input logic [2:0] c);
        if (!c[2]) return (c == 3'b001) ? 1 : 0;
        return c[0] ? 1 : 2;
    endfunction
    function automatic int h_core(input logic [2:0] c);
        return c[2] ? h_lead(c) : 0;
    endfunction
    function automatic int h_bus(input logic [2:0] c);
        if (!c[2]) return (c == 3'b001) ? 2 : 0;
        return h_lead(c) * (c[1] ? 1 : 2);
    endfunction
    function automatic int fmin(input int a, input int b);
        if (a == 0) return b;
        if (b == 0) return a;
        return (a < b) ? a : b;
    endfunction
    function automatic bit routed(input logic [2:0] p, input logic [2:0] n);
        return (p == 3'b000 && n != 3'b000 && n != 3'b001) ||
               (n == 3'b000 && p != 3'b000 && p != 3'b001);
    endfunction

    // Pulse-width monitor: every completed pulse must reach the current floor (R9, R10)
    int len_c = 0, len_e = 0, len_b = 0;
    logic pv_c = 1'b0, pv_e = 1'b0, pv_b = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            len_c = 0; len_e = 0; len_b = 0;
            pv_c = 1'b0; pv_e = 1'b0; pv_b = 1'b0;
        end else begin
            if (lead_clk_o !== pv_e) begin
                check(len_e >= floor_e, pv_e ? "R9" : "R10", "lead pulse width", len_e, floor_e);
                len_e = 1;
            end else len_e++;
            if (core_clk_o[0] !== pv_c) begin
                check(len_c >= floor_c, pv_c ? "R9" : "R10", "core pulse width", len_c, floor_c);
                len_c = 1;
            end else len_c++;
            if (sys_clk_o[0] !== pv_b) begin
                check(len_b >= floor_b, pv_b ? "R9" : "R10", "bus pulse width", len_b, floor_b);
                len_b = 1;
            end else len_b++;
            pv_e = lead_clk_o; pv_c = core_clk_o[0]; pv_b = sys_clk_o[0];
        end
    end

    // Move from the current code to n, setting pulse floors for the transition
    task automatic go(input logic [2:0] n);
        int fe, fc, fb;
        fe = fmin(h_lead(cur), h_lead(n));
        fc = fmin(h_core(cur), h_core(n));
        fb = fmin(h_bus(cur), h_bus(n));
        if (routed(cur, n)) begin
            fe = fmin(fe, 1);
            fb = fmin(fb, 2);
        end
        floor_e = (fe == 0) ? 1 : fe;
        floor_c = (fc == 0) ? 1 : fc;
        floor_b = (fb == 0) ? 1 : fb;
        {park_req_n, bus_wide_n, slow_req_n} = n;
        cur = n;
    endtask

    task automatic check_wave(input logic [31:0] v, input int h, input string req,
                              input string name);
        int r;
        bit ok;
        r = -1;
        ok = 1'b1;
        if (h == 0) begin
            ok = (v == 32'h0);
        end else begin
            for (int i = 1; i <= 2 * h + 1; i++)
                if (r < 0 && !v[i-1] && v[i]) r = i;
            if (r < 0) ok = 1'b0;
            else for (int i = 0; i < 16; i++)
                if (v[r+i] !== ((i % (2 * h)) < h)) ok = 1'b0;
        end
        check(ok, req, name, v, h);
    endtask

    // Settle in code c, then sample and compare against the computed waveforms
    task automatic measure(input logic [2:0] c, input bit route);
        logic [31:0] e, cp, b;
        bit saw, eq_ok, oe_ok, fix_ok, lag_ok;
        int cz;
        logic pe, oe_exp;
        logic [2:0] fix_exp;
        string tag;
        saw = 1'b0; cz = 0; pe = lead_clk_o;
        repeat (40) begin
            @(negedge clk);
            if (core_clk_o == '0) cz++; else cz = 0;
            if (cz >= 3 && lead_clk_o !== pe) saw = 1'b1;
            pe = lead_clk_o;
        end
        // R8: the parked stretch must appear on the way into or out of sleep
        if (route) check(saw, "R8", "lead toggles with core parked", saw, 1);
        eq_ok = 1'b1; oe_ok = 1'b1; fix_ok = 1'b1;
        oe_exp  = (c != 3'b010);
        fix_exp = (c == 3'b010) ? 3'b000 : (c == 3'b000) ? 3'b100 : 3'b111;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            e[i] = lead_clk_o; cp[i] = core_clk_o[0]; b[i] = sys_clk_o[0];
            if (core_clk_o !== {NCORE{core_clk_o[0]}} || sys_clk_o !== {NSYS{sys_clk_o[0]}})
                eq_ok = 1'b0;
            if (core_oe_o !== {NCORE{oe_exp}} || sys_oe_o !== {NSYS{oe_exp}} ||
                lead_oe_o !== oe_exp || fix_oe_o !== {3{oe_exp}}) oe_ok = 1'b0;
            if (fix_o !== fix_exp) fix_ok = 1'b0;
        end
        if (c[2]) tag = c[0] ? "R1" : "R2";
        else if (c == 3'b001) tag = "R4";
        else if (c == 3'b011) tag = "R5";
        else if (c == 3'b010) tag = "R6";
        else tag = "R7";
        check_wave(e, h_lead(c), tag, $sformatf("lead wave code %b", c));
        check_wave(cp, h_core(c), tag, $sformatf("core wave code %b", c));
        check_wave(b, h_bus(c), tag, $sformatf("bus wave code %b", c));
        // R3: identical bits and one-cycle lag of core behind lead
        check(eq_ok, "R3", "bit groups identical", core_clk_o, {NCORE{core_clk_o[0]}});
        if (h_core(c) != 0) begin
            lag_ok = 1'b1;
            for (int i = 1; i < 32; i++) if (cp[i] !== e[i-1]) lag_ok = 1'b0;
            check(lag_ok, "R3", "core lags lead by one", cp, e << 1);
        end
        check(oe_ok, "R6", $sformatf("output enables code %b", c), lead_oe_o, oe_exp);
        check(fix_ok, "R7", $sformatf("fixed gating code %b", c), fix_o, fix_exp);
    endtask

    initial begin
        rst_n = 1'b0;
        fix_i = 3'b111;
        {park_req_n, bus_wide_n, slow_req_n} = 3'b111;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(core_clk_o == '0 && lead_clk_o == 1'b0 && sys_clk_o == '0, "R12",
              "clocks low in reset", {core_clk_o, lead_clk_o, sys_clk_o}, 0);
        check(core_oe_o == '1 && lead_oe_o && sys_oe_o == '1 && fix_o == fix_i, "R12",
              "enables and fixed in reset", {lead_oe_o, fix_o}, 4'hf);
        rst_n = 1'b1;
        measure(3'b111, 1'b0);

        // R11: old rate persists for three edges after a ratio change
        begin
            logic s0, s1, s2, s3;
            @(negedge clk);
            s0 = lead_clk_o;
            go(3'b110);
            @(negedge clk); s1 = lead_clk_o;
            @(negedge clk); s2 = lead_clk_o;
            @(negedge clk); s3 = lead_clk_o;
            check(s1 != s0 && s2 != s1 && s3 != s2, "R11", "old rate held through sync",
                  {s0, s1, s2, s3}, 4'b0101 ^ {4{~s0}});
            measure(3'b110, 1'b0);
        end

        // All ordered pairs of control codes
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [2:0] pa, pb;
                bit ra, rb;
                pa = 3'(a); pb = 3'(b);
                ra = routed(cur, pa);
                go(pa);
                measure(pa, ra);
                rb = routed(cur, pb);
                go(pb);
                measure(pb, rb);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule